// File: doc/BRIEF.md
# Timer capture/compare channel pair

This block gives a chip two timer channels that share one free-running up-counter. Each channel has an 8-bit control/status register, a counter-wide value register and one pin. A channel can timestamp edges on its pin (input capture) or act on its pin when the counter reaches its value (output compare). Channel 0 has one further mode, buffered compare. In that mode it borrows channel 1's value register as a second buffer and shuts channel 1 down.

Software sees the block through a simple synchronous register bus. Read data is combinational from the address. The read and write strobes take effect at the clock edge. Each channel has an event flag that raises an interrupt request when enabled. The flag can only be cleared by a two-step handshake, and a new event can never be lost by a badly timed clear. The counter's all-ones cycle is signalled by an overflow pulse. A toggle-on-overflow bit and a force-high (full duty) bit serve as simple PWM hooks.

Top module: `tmr_cc_pair`

## Requirements
- R1: After reset both control registers, both value registers, `irq` and `pin_oe` are 0.
- R2: The counter starts at 0, adds 1 every clock, wraps from all-ones to 0, and reads at bus address 4. `ovf_pulse` is 1 exactly in the all-ones cycle.
- R3: The bus addresses are: 0 for channel 0 control, 1 for channel 0 value, 2 for channel 1 control, 3 for channel 1 value. Control bits are: 7 flag, 6 interrupt enable, 5 buffered mode (channel 0 only), 4 compare mode, 3:2 edge/action select, 1 toggle on overflow, 0 force high. Bit 5 of channel 1 always reads 0.
- R4: Input capture is selected by compare mode 0 with a nonzero edge select. Select 01 captures rising edges, 10 falling edges and 11 both. A capture sets the flag and loads the value register with the counter value that was readable when the pin changed, plus 2.
- R5: Compare mode 1 with a nonzero select is output compare. When the counter equals the value register, the flag is set and at that clock edge the pin toggles (01), goes to 0 (10) or goes to 1 (11). `pin_oe` is 1 in this mode.
- R6: Edge select 00 disconnects the channel: `pin_oe` is 0 and no event ever sets the flag.
- R7: The flag clears only when a control-register read that sees the flag set is followed by a write with bit 7 = 0. A write with no such read leaves the flag set. Writing 1 to bit 7 has no effect.
- R8: If an event occurs between the qualifying read and the write of 0, that write leaves the flag set.
- R9: `irq` of a channel is 1 exactly when its flag and its interrupt enable are both 1.
- R10: In compare mode the toggle-on-overflow bit inverts the pin in the all-ones counter cycle, and the force-high bit holds `pin_out` at 1.
- R11: In buffered mode channel 0 compares against an active value. At each counter overflow this active value is loaded from whichever value register (address 1 or 3) was written last, so a new value takes effect only from the next counter period.
- R12: While buffered mode is set, channel 1 control reads 0, writes to it are ignored, `pin_oe[1]` is 0 and `irq[1]` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data for `bus_addr` |
| pin_in | input | 2 | Channel pin levels (asynchronous) |
| pin_out | output | 2 | Channel pin drive value |
| pin_oe | output | 2 | Channel pin drive enable; 0 leaves the pin to general-purpose use |
| ovf_pulse | output | 1 | High in the counter's all-ones cycle |
| irq | output | 2 | Per-channel interrupt request |

## Verification
Capture is driven with random edge-select codes and random pin levels. Rising, falling and unchanged pins are told apart by whether the flag rises, and each hit also checks the captured count against the pin's change time. Compare is run once for each pin action, each time from a known pin level, so toggle, clear and set show up as distinct results. The overflow toggle and the force-high bit are observed at fixed counter positions. Buffered mode is checked at counter positions before and after an overflow, which shows when a new value takes effect and that the last-written register is the one used. The flag handshake is run with no read, with a write of 1, and with an event placed between the read and the write, so a lost event or a false clear would show.

// File: rtl/tmrcc_pkg.sv
package tmrcc_pkg;
    localparam int ADDR_W = 3;
    localparam logic [ADDR_W-1:0] A_CTL0 = 3'd0;
    localparam logic [ADDR_W-1:0] A_VAL0 = 3'd1;
    localparam logic [ADDR_W-1:0] A_CTL1 = 3'd2;
    localparam logic [ADDR_W-1:0] A_VAL1 = 3'd3;
    localparam logic [ADDR_W-1:0] A_CNT  = 3'd4;

    typedef enum logic [1:0] {CH_OFF, CH_CAPT, CH_CMP, CH_CMP_BUF} ch_mode_e;

    // control/status byte, bit 7 down to bit 0
    typedef struct packed {
        logic       flag;
        logic       ie;
        logic       bufm;
        logic       cmpm;
        logic [1:0] els;
        logic       tov;
        logic       maxd;
    } ctl_t;
endpackage

// File: rtl/tmrcc_count.sv
module tmrcc_count #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] cnt,
    output logic         top
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb cnt_d = cnt_q + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
    assign top = &cnt_q;
endmodule

// File: rtl/tmrcc_edge.sv
module tmrcc_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic prev;
    } sy_t;
    sy_t y_d, y_q;

    always_comb begin
        y_d.s1   = pin;
        y_d.s2   = y_q.s1;
        y_d.prev = y_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) y_q <= '0;
        else        y_q <= y_d;
    end

    assign rise = y_q.s2 & ~y_q.prev;
    assign fall = ~y_q.s2 & y_q.prev;
endmodule

// File: rtl/tmrcc_chan.sv
module tmrcc_chan
    import tmrcc_pkg::*;
#(
    parameter int W       = 16,
    parameter bit HAS_BUF = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable,
    input  logic [W-1:0] cnt,
    input  logic         cnt_top,
    input  logic         rise,
    input  logic         fall,
    input  logic         ctl_wr,
    input  logic         ctl_rd,
    input  logic         val_wr,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] ext_cmp,
    output ctl_t         ctl_o,
    output logic [W-1:0] val_o,
    output logic         pin_out,
    output logic         pin_oe,
    output logic         irq
);
    localparam logic [7:0] WMASK = HAS_BUF ? 8'hFF : 8'hDF;

    typedef struct packed {
        ctl_t         ctl;
        logic [W-1:0] val;
        logic         arm;
        logic         lvl;
    } st_t;
    st_t s_d, s_q;

    ch_mode_e     mode;
    logic [W-1:0] cmp_ref;
    logic         evt;
    logic         drive;

    always_comb begin
        if (!enable || s_q.ctl.els == 2'b00) mode = CH_OFF;
        else if (HAS_BUF && s_q.ctl.bufm)    mode = CH_CMP_BUF;
        else if (s_q.ctl.cmpm)               mode = CH_CMP;
        else                                 mode = CH_CAPT;
    end

    assign drive   = (mode == CH_CMP) || (mode == CH_CMP_BUF);
    assign cmp_ref = (mode == CH_CMP_BUF) ? ext_cmp : s_q.val;

    always_comb begin
        case (mode)
            CH_CAPT:            evt = (s_q.ctl.els[0] & rise) | (s_q.ctl.els[1] & fall);
            CH_CMP, CH_CMP_BUF: evt = (cnt == cmp_ref);
            default:            evt = 1'b0;
        endcase
    end

    always_comb begin
        s_d = s_q;
        // a read that sees the flag set arms the clear
        if (ctl_rd && s_q.ctl.flag) s_d.arm = 1'b1;
        if (ctl_wr) begin
            s_d.ctl      = ctl_t'(wdata[7:0] & WMASK);
            s_d.ctl.flag = s_q.ctl.flag & ~(s_q.arm & ~wdata[7]);
            s_d.arm      = 1'b0;
        end
        if (val_wr) s_d.val = wdata;
        if (evt) begin
            s_d.ctl.flag = 1'b1;
            s_d.arm      = 1'b0;
            if (mode == CH_CAPT) s_d.val = cnt;
        end
        if (drive) begin
            if (evt) begin
                case (s_q.ctl.els)
                    2'b01:   s_d.lvl = ~s_q.lvl;
                    2'b10:   s_d.lvl = 1'b0;
                    default: s_d.lvl = 1'b1;
                endcase
            end else if (s_q.ctl.tov && cnt_top) begin
                s_d.lvl = ~s_q.lvl;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ctl_o   = s_q.ctl;
    assign val_o   = s_q.val;
    assign pin_oe  = drive;
    assign pin_out = drive & (s_q.ctl.maxd | s_q.lvl);
    assign irq     = enable & s_q.ctl.flag & s_q.ctl.ie;
endmodule

// File: rtl/tmr_cc_pair.sv
module tmr_cc_pair
    import tmrcc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    input  logic [1:0]        pin_in,
    output logic [1:0]        pin_out,
    output logic [1:0]        pin_oe,
    output logic              ovf_pulse,
    output logic [1:0]        irq
);
    localparam int N_CH = 2;

    logic [CNT_W-1:0] cnt_w;
    logic             cnt_top;
    ctl_t             ctl_w [N_CH];
    logic [CNT_W-1:0] val_w [N_CH];
    logic [N_CH-1:0]  rise_w, fall_w;
    logic             buf_mode;

    typedef struct packed {
        logic             sel;
        logic [CNT_W-1:0] act;
    } bst_t;
    bst_t b_d, b_q;

    assign buf_mode = ctl_w[0].bufm;

    tmrcc_count #(.W(CNT_W)) u_cnt (
        .clk (clk),
        .rst_n (rst_n),
        .cnt (cnt_w),
        .top (cnt_top)
    );

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        localparam logic [2:0] A_C = 3'(2 * i);
        localparam logic [2:0] A_V = 3'(2 * i + 1);
        logic en;
        assign en = (i == 0) ? 1'b1 : !buf_mode;

        tmrcc_edge u_edge (
            .clk (clk),
            .rst_n (rst_n),
            .pin (pin_in[i]),
            .rise (rise_w[i]),
            .fall (fall_w[i])
        );

        tmrcc_chan #(.W(CNT_W), .HAS_BUF(i == 0)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .enable  (en),
            .cnt     (cnt_w),
            .cnt_top (cnt_top),
            .rise    (rise_w[i]),
            .fall    (fall_w[i]),
            .ctl_wr  (bus_wr && bus_addr == A_C && en),
            .ctl_rd  (bus_rd && bus_addr == A_C && en),
            .val_wr  (bus_wr && bus_addr == A_V),
            .wdata   (bus_wdata),
            .ext_cmp (b_q.act),
            .ctl_o   (ctl_w[i]),
            .val_o   (val_w[i]),
            .pin_out (pin_out[i]),
            .pin_oe  (pin_oe[i]),
            .irq     (irq[i])
        );
    end

    // buffered compare: remember the last-written value register, swap in at overflow
    always_comb begin
        b_d = b_q;
        if (bus_wr && bus_addr == A_VAL0) b_d.sel = 1'b0;
        if (bus_wr && bus_addr == A_VAL1) b_d.sel = 1'b1;
        if (cnt_top) b_d.act = b_q.sel ? val_w[1] : val_w[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end

    always_comb begin
        case (bus_addr)
            A_CTL0:  bus_rdata = CNT_W'(ctl_w[0]);
            A_VAL0:  bus_rdata = val_w[0];
            A_CTL1:  bus_rdata = buf_mode ? '0 : CNT_W'(ctl_w[1]);
            A_VAL1:  bus_rdata = val_w[1];
            A_CNT:   bus_rdata = cnt_w;
            default: bus_rdata = '0;
        endcase
    end

    assign ovf_pulse = cnt_top;
endmodule

// File: rtl/tmrcc_chk.sv
module tmrcc_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic [2:0]   bus_addr,
    input logic         bus_wr,
    input logic [W-1:0] bus_wdata,
    input logic [W-1:0] bus_rdata,
    input logic [1:0]   pin_oe,
    input logic         ovf_pulse,
    input logic [1:0]   irq,
    input logic [W-1:0] cnt,
    input logic         flag0,
    input logic         buf_mode
);
    assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |=> cnt == '0);

    assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ovf_pulse |=> cnt == $past(cnt) + 1'b1);

    assert_bit5_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr == 3'd2 |-> !bus_rdata[5]);

    assert_flag_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flag0 && !(bus_wr && bus_addr == 3'd0) |=> flag0);

    assert_clear_path_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag0) |-> $past(bus_wr && bus_addr == 3'd0 && !bus_wdata[7]));

    assert_irq_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq[0] |-> flag0);

    assert_ch1_off_R12: assert property (@(posedge clk) disable iff (!rst_n)
        buf_mode |-> !irq[1] && !pin_oe[1]);
endmodule

bind tmr_cc_pair tmrcc_chk #(.W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_oe    (pin_oe),
    .ovf_pulse (ovf_pulse),
    .irq       (irq),
    .cnt       (cnt_w),
    .flag0     (ctl_w[0].flag),
    .buf_mode  (buf_mode)
);

// File: tb/sim_tmr_cc_pair.sv
`timescale 1ns/1ps
module sim_tmr_cc_pair;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [2:0]   bus_addr = '0;
    logic         bus_rd = 1'b0;
    logic         bus_wr = 1'b0;
    logic [W-1:0] bus_wdata = '0;
    logic [W-1:0] bus_rdata;
    logic [1:0]   pin_in = '0;
    logic [1:0]   pin_out, pin_oe, irq;
    logic         ovf_pulse;

    int  errs = 0;
    int  chks = 0;
    bit  done = 1'b0;

    always #2 clk = ~clk;

    tmr_cc_pair #(.CNT_W(W)) u0 (
        .clk (clk), .rst_n (rst_n),
        .bus_addr (bus_addr), .bus_rd (bus_rd), .bus_wr (bus_wr),
        .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
        .pin_in (pin_in), .pin_out (pin_out), .pin_oe (pin_oe),
        .ovf_pulse (ovf_pulse), .irq (irq)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        chks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic peek(output logic [7:0] c);
        @(negedge clk);
        bus_addr = 3'd4;
        #1 c = bus_rdata;
    endtask

    task automatic wait_cnt(input logic [7:0] v);
        logic [7:0] c;
        int n = 0;
        do begin peek(c); n++; end while (c !== v && n < 1000);
    endtask

    task automatic cap_drive(input int ch, input logic v, output logic [7:0] c0);
        @(negedge clk);
        pin_in[ch] = v; bus_addr = 3'd4;
        #1 c0 = bus_rdata;
        repeat (3) @(posedge clk);
    endtask

    task automatic cfg_clear(input logic [2:0] a, input logic [7:0] c);
        logic [7:0] t;
        wr(a, c); rd(a, t); wr(a, c);
    endtask

    function automatic logic exp_hit(input logic [1:0] els, input logic o, input logic n);
        return (els[0] && !o && n) || (els[1] && o && !n);
    endfunction

    initial begin
        logic [7:0] d, c0, c1;
        logic [1:0] els;
        logic nv, cur, hitx;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(3'd0, d); chk("R1 ctl0", d, 8'h00);
        rd(3'd1, d); chk("R1 val0", d, 8'h00);
        rd(3'd2, d); chk("R1 ctl1", d, 8'h00);
        rd(3'd3, d); chk("R1 val1", d, 8'h00);
        chk("R1 irq", {6'b0, irq}, 8'h00);
        chk("R1 pin_oe", {6'b0, pin_oe}, 8'h00);

        // R2 counter
        peek(c0); peek(c1); chk("R2 step", c1, c0 + 8'd1);
        wait_cnt(8'hFF); chk("R2 ovf high", {7'b0, ovf_pulse}, 8'h01);
        peek(c0); chk("R2 wrap", c0, 8'h00);
        chk("R2 ovf low", {7'b0, ovf_pulse}, 8'h00);

        // R3 layout
        wr(3'd2, 8'h7F); rd(3'd2, d); chk("R3 ch1 bit5 zero", {1'b0, d[6:0]}, 8'h5F);
        wr(3'd2, 8'h00);
        wr(3'd0, 8'h5E); rd(3'd0, d); chk("R3 ch0 readback", {1'b0, d[6:0]}, 8'h5E);
        wr(3'd0, 8'h00);

        // R4 capture, random edge selects and pin levels
        cur = 1'b0;
        for (int k = 0; k < 24; k++) begin
            els = 2'($urandom_range(1, 3));
            nv  = (k == 0) ? 1'b1 : 1'($urandom_range(0, 1));
            cfg_clear(3'd0, {4'b0, els, 2'b0});
            cap_drive(0, nv, c0);
            hitx = exp_hit(els, cur, nv);
            rd(3'd0, d); chk("R4 flag", {7'b0, d[7]}, {7'b0, hitx});
            if (hitx) begin
                rd(3'd1, d); chk("R4 captured count", d, c0 + 8'd2);
            end
            cur = nv;
        end

        // R6 disconnected
        cfg_clear(3'd0, 8'h10);
        chk("R6 pin_oe", {7'b0, pin_oe[0]}, 8'h00);
        repeat (260) @(posedge clk);
        rd(3'd0, d); chk("R6 no event", {7'b0, d[7]}, 8'h00);

        // R5 compare actions: clear, set, toggle
        peek(c0); wr(3'd1, c0 + 8'd30); cfg_clear(3'd0, 8'h18);
        rd(3'd0, d); chk("R5 no early flag", {7'b0, d[7]}, 8'h00);
        chk("R5 pin_oe", {7'b0, pin_oe[0]}, 8'h01);
        repeat (40) @(posedge clk);
        rd(3'd0, d); chk("R5 flag at match", {7'b0, d[7]}, 8'h01);
        chk("R5 clear action", {7'b0, pin_out[0]}, 8'h00);
        peek(c0); wr(3'd1, c0 + 8'd30); cfg_clear(3'd0, 8'h1C);
        repeat (40) @(posedge clk); @(negedge clk);
        chk("R5 set action", {7'b0, pin_out[0]}, 8'h01);
        peek(c0); wr(3'd1, c0 + 8'd30); cfg_clear(3'd0, 8'h14);
        repeat (40) @(posedge clk); @(negedge clk);
        chk("R5 toggle action", {7'b0, pin_out[0]}, 8'h00);

        // R10 overflow toggle and force high
        wr(3'd1, 8'h80); wr(3'd0, 8'h1E);
        wait_cnt(8'h90); chk("R10 set before ovf", {7'b0, pin_out[0]}, 8'h01);
        wait_cnt(8'h10); chk("R10 toggled at ovf", {7'b0, pin_out[0]}, 8'h00);
        wr(3'd0, 8'h1F); @(negedge clk);
        chk("R10 force high", {7'b0, pin_out[0]}, 8'h01);
        wr(3'd0, 8'h00);

        // R7 clear handshake on channel 1 (rising capture)
        wr(3'd2, 8'h04);
        cap_drive(1, 1'b1, c0);
        wr(3'd2, 8'h04);
        rd(3'd2, d); chk("R7 write0 without read", {7'b0, d[7]}, 8'h01);
        wr(3'd2, 8'h84);
        rd(3'd2, d); chk("R7 write1 no effect", d, 8'h84);
        wr(3'd2, 8'h04);
        rd(3'd2, d); chk("R7 cleared", d, 8'h04);

        // R8 event between read and write
        cap_drive(1, 1'b0, c0);
        cap_drive(1, 1'b1, c0);
        rd(3'd2, d);
        cap_drive(1, 1'b0, c0);
        cap_drive(1, 1'b1, c0);
        wr(3'd2, 8'h04);
        rd(3'd2, d); chk("R8 flag kept", {7'b0, d[7]}, 8'h01);

        // R9 interrupt
        chk("R9 irq off without enable", {7'b0, irq[1]}, 8'h00);
        wr(3'd2, 8'hC4); @(negedge clk);
        chk("R9 irq on", {7'b0, irq[1]}, 8'h01);
        rd(3'd2, d); wr(3'd2, 8'h44); @(negedge clk);
        chk("R9 irq off after clear", {7'b0, irq[1]}, 8'h00);

        // R12 channel 1 disabled by buffered mode
        wr(3'd3, 8'h00); cfg_clear(3'd2, 8'h54);
        repeat (260) @(posedge clk); @(negedge clk);
        chk("R12 ch1 irq before", {7'b0, irq[1]}, 8'h01);
        chk("R12 ch1 oe before", {7'b0, pin_oe[1]}, 8'h01);
        wr(3'd1, 8'h02); wr(3'd0, 8'h24); @(negedge clk);
        chk("R12 ch1 irq masked", {7'b0, irq[1]}, 8'h00);
        chk("R12 ch1 oe released", {7'b0, pin_oe[1]}, 8'h00);
        rd(3'd2, d); chk("R12 ch1 reads zero", d, 8'h00);
        wr(3'd2, 8'h00);

        // R11 buffered compare
        wait_cnt(8'hF0); wait_cnt(8'h05);
        wr(3'd1, 8'h80); cfg_clear(3'd0, 8'h24);
        wait_cnt(8'h90); rd(3'd0, d); chk("R11 not active yet", {7'b0, d[7]}, 8'h00);
        wait_cnt(8'h70); rd(3'd0, d); chk("R11 none before match", {7'b0, d[7]}, 8'h00);
        wait_cnt(8'h90); rd(3'd0, d); chk("R11 active after ovf", {7'b0, d[7]}, 8'h01);
        wr(3'd3, 8'h30); cfg_clear(3'd0, 8'h24);
        wait_cnt(8'h10); rd(3'd0, d); chk("R11 other reg pending", {7'b0, d[7]}, 8'h00);
        wait_cnt(8'h40); rd(3'd0, d); chk("R11 last written used", {7'b0, d[7]}, 8'h01);
        wr(3'd0, 8'h00);
        rd(3'd2, d); chk("R12 write ignored", d, 8'hD4);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, chks);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            errs++; chks++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errs, chks);
            $finish;
        end
    end
endmodule